// File: doc/BRIEF.md
# Clock Alarm and Interrupt Unit

This block sits beside a running time-of-day counter. It holds a programmed alarm time of seconds, minutes, hours and an AM/PM bit, all in BCD. On every one-second event from the counter it compares the current time with the stored alarm. On a match it sets a sticky alarm flag. It also latches a set of rollover event pulses from the counter into sticky flags of their own.

Each flag has an enable bit. The interrupt output is high while any flag and its enable are both set. Software clears a flag by writing a 1 to its position, so the usual sequence is safe: disable the alarm enable, rewrite the alarm time, clear the flag, then enable again. The comparison runs on every second of the day, so any alarm time within the next 24 hours is reached. The AM/PM bit takes part in the comparison only when the counter runs in 12-hour mode.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset all flags, all enables and the stored alarm time are zero, and `irq` is low.
- R2: A cycle with `alm_we` = 1 stores the alarm fields. The current time matches when the seconds, minutes and hours codes are equal. The codes are BCD: seconds and minutes are bits [6:4] tens and [3:0] units, and hours are bits [5:4] tens and [3:0] units. Any valid time of day can match, including 23:59:59 (hours 0x23, minutes 0x59, seconds 0x59).
- R3: When `mode_12h` = 1 the alarm AM/PM bit must also equal `cur_pm` for a match. When `mode_12h` = 0 the two PM bits are ignored.
- R4: The alarm flag is `flags[0]`. It sets on the clock edge that ends a cycle with `sec_tick` = 1 and a match, and the new value is visible from the next cycle. A matching time without `sec_tick` never sets it.
- R5: `roll_evt[i]` = 1 in a cycle sets `flags[i+1]` at the same clock edge.
- R6: Flags are sticky. A 1 in `flag_clr[i]` clears `flags[i]` at the edge. A 0 in `flag_clr` leaves the flag unchanged.
- R7: When a set event and a clear of the same flag fall in one cycle, the flag ends up set.
- R8: Flags set whatever the state of their enables.
- R9: `ien` is loaded from `ien_wdata` on `alm_we`-independent strobe `ien_we`. `irq` is high exactly while some bit i has both `flags[i]` and `ien[i]` set, with no extra cycle of delay.
- R10: When an alarm write and `sec_tick` fall in the same cycle, the comparison in that cycle uses the alarm value stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_12h | input | 1 | 1 = counter is in 12-hour mode |
| sec_tick | input | 1 | One-second event from the counter |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current PM indicator |
| roll_evt | input | N_ROLL | Rollover event pulses from the counter |
| alm_we | input | 1 | Alarm time write strobe |
| alm_sec | input | 7 | Alarm seconds, BCD |
| alm_min | input | 7 | Alarm minutes, BCD |
| alm_hour | input | 6 | Alarm hours, BCD |
| alm_pm | input | 1 | Alarm PM bit |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | N_ROLL+1 | Enable register write data |
| flag_clr | input | N_ROLL+1 | Write-1-to-clear strobes for the flags |
| flags | output | N_ROLL+1 | Sticky flags; bit 0 is the alarm |
| ien | output | N_ROLL+1 | Enable register |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can fall in one cycle. A flag's set event and its write-1 clear can coincide, and an alarm write can coincide with a one-second event. The bench provokes the first by pulsing a matching `sec_tick`, or a rollover pulse, together with the matching `flag_clr` bit, and it expects the flag to read 1 afterwards. It provokes the second by writing an alarm equal to the current time in the tick cycle, and it expects no flag until the next matching tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;

  typedef struct packed {
    logic              pm;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } bcd_time_t;

  // Equality of two BCD times; the PM bit counts only in 12-hour mode.
  function automatic logic time_match(input bcd_time_t a, input bcd_time_t b,
                                      input logic use_pm);
    logic same_hms;
    same_hms = (a.sec == b.sec) && (a.min == b.min) && (a.hour == b.hour);
    return same_hms && (!use_pm || (a.pm == b.pm));
  endfunction

  // Sticky flag update: a set event beats a clear.
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  bcd_time_t wdata,
  output bcd_time_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (we) q <= wdata;
  end

  // R2: the stored alarm changes only on a write
  p_alarm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  // R2: a write lands in the register
  p_alarm_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_12h,
  input  logic      sec_tick,
  input  bcd_time_t now,
  input  bcd_time_t alarm,
  output logic      match_w,
  output logic      hit_w
);

  assign match_w = time_match(now, alarm, mode_12h);
  assign hit_w   = sec_tick & match_w;

  // R3: in 24-hour mode a PM difference cannot block a match
  p_pm_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_12h && now.sec == alarm.sec && now.min == alarm.min &&
     now.hour == alarm.hour) |-> match_w);

  // R3: in 12-hour mode a PM difference always blocks a match
  p_pm_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_12h && now.pm != alarm.pm) |-> !match_w);

  // R4: no hit outside a one-second event
  p_hit_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> !hit_w);

endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import rtc_alarm_pkg::*;
#(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic          ien_we,
  input  logic [NF-1:0] ien_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] ien,
  output logic          irq
);

  logic [NF-1:0] active_w;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], set_vec[i], clr_vec[i]);
    end

    assign active_w[i] = flags[i] & ien[i];

    // R7 and R8: a set event always leaves the flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);

    // R6: a clear without a set empties the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flags[i]);

    // R6: with neither strobe the flag holds
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flags[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien <= '0;
    else if (ien_we) ien <= ien_wdata;
  end

  assign irq = |active_w;

  // R9: the request can only rise after a set event or an enable write
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|set_vec) || ien_we));

  // R9: the request can only fall after a clear or an enable write
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past((|clr_vec) || ien_we));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int N_ROLL = 3,
  localparam int NF = N_ROLL + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_12h,
  input  logic              sec_tick,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic              cur_pm,
  input  logic [N_ROLL-1:0] roll_evt,
  input  logic              alm_we,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic              alm_pm,
  input  logic              ien_we,
  input  logic [NF-1:0]     ien_wdata,
  input  logic [NF-1:0]     flag_clr,
  output logic [NF-1:0]     flags,
  output logic [NF-1:0]     ien,
  output logic              irq
);

  bcd_time_t     now_w, alm_wdata_w, alm_q;
  logic          match_w, hit_w;
  logic [NF-1:0] set_vec;

  assign now_w       = '{pm: cur_pm, hour: cur_hour, min: cur_min, sec: cur_sec};
  assign alm_wdata_w = '{pm: alm_pm, hour: alm_hour, min: alm_min, sec: alm_sec};

  alarm_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (alm_we),
    .wdata (alm_wdata_w),
    .q     (alm_q)
  );

  alarm_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_12h (mode_12h),
    .sec_tick (sec_tick),
    .now      (now_w),
    .alarm    (alm_q),
    .match_w  (match_w),
    .hit_w    (hit_w)
  );

  assign set_vec = {roll_evt, hit_w};

  irq_flags #(.NF(NF)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (flag_clr),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .flags     (flags),
    .ien       (ien),
    .irq       (irq)
  );

  // R4: the alarm flag rises only after a matching one-second event
  p_alarm_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(sec_tick && match_w));

  // R10: a tick with a fresh write compares against the old alarm
  p_old_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alm_we && !match_w && !flag_clr[0] && !flags[0]) |=> !flags[0]);

endmodule

// File: tb/test_rtc_alarm_irq.sv
`timescale 1ns/100ps
module test_rtc_alarm_irq;

  localparam int NR = 3;
  localparam int NF = NR + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_12h = 1'b0;
  logic          sec_tick = 1'b0;
  logic [6:0]    cur_sec = '0, cur_min = '0, alm_sec = '0, alm_min = '0;
  logic [5:0]    cur_hour = '0, alm_hour = '0;
  logic          cur_pm = 1'b0, alm_pm = 1'b0;
  logic [NR-1:0] roll_evt = '0;
  logic          alm_we = 1'b0, ien_we = 1'b0;
  logic [NF-1:0] ien_wdata = '0, flag_clr = '0;
  logic [NF-1:0] flags, ien;
  logic          irq;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq #(.N_ROLL(NR)) i_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .mode_12h(mode_12h), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_pm(cur_pm),
    .roll_evt(roll_evt), .alm_we(alm_we), .alm_sec(alm_sec), .alm_min(alm_min),
    .alm_hour(alm_hour), .alm_pm(alm_pm), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .flag_clr(flag_clr), .flags(flags), .ien(ien), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected request computed bit by bit from flags and enables
  function automatic logic want_irq(input logic [NF-1:0] f, input logic [NF-1:0] e);
    logic r = 1'b0;
    for (int i = 0; i < NF; i++) if (f[i] && e[i]) r = 1'b1;
    return r;
  endfunction

  task automatic set_now(input logic [5:0] h, input logic [6:0] m,
                         input logic [6:0] s, input logic pm);
    cur_hour = h; cur_min = m; cur_sec = s; cur_pm = pm;
  endtask

  task automatic write_alarm(input logic [5:0] h, input logic [6:0] m,
                             input logic [6:0] s, input logic pm);
    alm_hour = h; alm_min = m; alm_sec = s; alm_pm = pm; alm_we = 1'b1;
    @(negedge clk); alm_we = 1'b0;
  endtask

  task automatic pulse_tick();
    sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic clear(input logic [NF-1:0] m);
    flag_clr = m; @(negedge clk); flag_clr = '0;
  endtask

  task automatic write_ien(input logic [NF-1:0] v);
    ien_wdata = v; ien_we = 1'b1; @(negedge clk); ien_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "flags", flags, 0);
    check("R1", "ien", ien, 0);
    check("R1", "irq", irq, 0);
    // zero alarm matches 00:00:00 after reset
    set_now(6'h00, 7'h00, 7'h00, 1'b0); pulse_tick();
    check("R1", "zero alarm hit", flags[0], 1);
    clear('1);
  endtask

  task automatic t_basic_match();
    write_alarm(6'h12, 7'h34, 7'h56, 1'b0);
    set_now(6'h12, 7'h34, 7'h55, 1'b0); pulse_tick();
    check("R2", "near miss", flags[0], 0);
    set_now(6'h12, 7'h35, 7'h56, 1'b0); pulse_tick();
    check("R2", "minute miss", flags[0], 0);
    set_now(6'h12, 7'h34, 7'h56, 1'b0); pulse_tick();
    check("R2", "exact match", flags[0], 1);
    check("R8", "irq while disabled", irq, 0);
    write_ien(4'b0001);
    check("R9", "irq enabled", irq, want_irq(flags, 4'b0001));
    check("R9", "irq high", irq, 1);
    clear(4'b0001);
    check("R6", "cleared", flags[0], 0);
    check("R9", "irq after clear", irq, 0);
  endtask

  task automatic t_late_day();
    write_alarm(6'h23, 7'h59, 7'h59, 1'b0);
    set_now(6'h23, 7'h59, 7'h59, 1'b0); pulse_tick();
    check("R2", "23:59:59", flags[0], 1);
    clear(4'b0001);
  endtask

  task automatic t_no_tick();
    write_alarm(6'h07, 7'h00, 7'h30, 1'b0);
    set_now(6'h07, 7'h00, 7'h30, 1'b0);
    repeat (5) @(negedge clk);
    check("R4", "match without tick", flags[0], 0);
    pulse_tick();
    check("R4", "single tick", flags[0], 1);
    clear(4'b0001);
    repeat (4) @(negedge clk);
    check("R4", "no refire without tick", flags[0], 0);
  endtask

  task automatic t_pm();
    mode_12h = 1'b1;
    write_alarm(6'h11, 7'h15, 7'h00, 1'b1);
    set_now(6'h11, 7'h15, 7'h00, 1'b0); pulse_tick();
    check("R3", "12h pm differs", flags[0], 0);
    set_now(6'h11, 7'h15, 7'h00, 1'b1); pulse_tick();
    check("R3", "12h pm equal", flags[0], 1);
    clear(4'b0001);
    mode_12h = 1'b0;
    set_now(6'h11, 7'h15, 7'h00, 1'b0); pulse_tick();
    check("R3", "24h pm ignored", flags[0], 1);
    clear(4'b0001);
  endtask

  task automatic t_rollover();
    roll_evt = 3'b100; @(negedge clk); roll_evt = '0;
    check("R5", "roll bit 2", flags, 4'b1000);
    roll_evt = 3'b001; @(negedge clk); roll_evt = '0;
    check("R5", "roll bit 0", flags, 4'b1010);
    clear(4'b0101);
    check("R6", "zero bits keep", flags, 4'b1010);
    write_ien(4'b1000);
    check("R9", "irq from roll", irq, 1);
    clear(4'b1000);
    check("R9", "irq dropped", irq, 0);
    check("R6", "partial clear", flags, 4'b0010);
    clear(4'b0010);
  endtask

  task automatic t_set_vs_clear();
    roll_evt = 3'b010; flag_clr = 4'b0100; @(negedge clk);
    roll_evt = '0; flag_clr = '0;
    check("R7", "roll set beats clear", flags[2], 1);
    write_alarm(6'h01, 7'h02, 7'h03, 1'b0);
    set_now(6'h01, 7'h02, 7'h03, 1'b0);
    sec_tick = 1'b1; flag_clr = 4'b0001; @(negedge clk);
    sec_tick = 1'b0; flag_clr = '0;
    check("R7", "alarm set beats clear", flags[0], 1);
    clear('1);
    check("R6", "all cleared", flags, 0);
  endtask

  task automatic t_write_with_tick();
    write_alarm(6'h05, 7'h05, 7'h05, 1'b0);
    set_now(6'h09, 7'h10, 7'h20, 1'b0);
    alm_hour = 6'h09; alm_min = 7'h10; alm_sec = 7'h20; alm_pm = 1'b0;
    alm_we = 1'b1; sec_tick = 1'b1; @(negedge clk);
    alm_we = 1'b0; sec_tick = 1'b0;
    check("R10", "old alarm used", flags[0], 0);
    pulse_tick();
    check("R10", "new alarm next tick", flags[0], 1);
    clear(4'b0001);
  endtask

  task automatic t_safe_rewrite();
    write_ien(4'b0001);
    set_now(6'h08, 7'h00, 7'h00, 1'b0);
    write_ien(4'b0000);
    write_alarm(6'h08, 7'h00, 7'h00, 1'b0);
    pulse_tick();
    check("R8", "flag sets while disabled", flags[0], 1);
    check("R9", "no irq while disabled", irq, 0);
    clear(4'b0001);
    write_ien(4'b0001);
    check("R9", "no spurious irq", irq, 0);
    pulse_tick();
    check("R9", "irq on next match", irq, 1);
    clear(4'b0001);
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_match();
    t_late_day();
    t_no_tick();
    t_pm();
    t_rollover();
    t_set_vs_clear();
    t_write_with_tick();
    t_safe_rewrite();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule